// File: doc/BRIEF.md
# Ring-Chained Deep FIFO

This block joins several identical storage slices into one first-in/first-out queue whose capacity is the slice count times the slice depth. Every slice keeps its own memory, its own write and read pointers and its own fill count. No slice holds the whole queue's state. Two ownership tokens travel around a ring of slices instead. The write token marks the slice that takes the next incoming word, and the read token marks the slice that delivers the next outgoing word.

When a slice stores a word into its final location, it raises a write-pass strobe towards its successor and gives up the write token. A slice that delivers the word from its final location does the same on a separate read-pass strobe. The successor claims the token on the following clock. The last slice feeds the first, which closes the ring. After reset, the slice strapped as first load (strap low) owns both tokens.

Writes and reads are broadcast to all slices, and only the owner of the matching token acts on them. The queue-level full flag is built from the full flags of all slices, and the queue-level empty flag from their empty flags. Half-full indication and replay of stored data are not provided in this chained arrangement. With one slice, the expansion input is tied low and the slice runs alone, keeping both tokens permanently.

Top module: `ring_fifo`

## Requirements
- R1: While reset is low and on the first clock after its release, `empty` is 1, `full` is 0, `rd_valid` is 0 and `rd_data` is all zeros. Slice 0 owns both tokens, so the first word written is the first word read.
- R2: Words leave in the order they were written, including across slice boundaries. Up to N_SLICES*SLICE_DEPTH words can be held at once.
- R3: `full` is 1 exactly when N_SLICES*SLICE_DEPTH words are held. A write requested while `full` is 1 is dropped, and its data never appears on `rd_data`.
- R4: `empty` is 1 exactly when no word is held. A read requested while `empty` is 1 is dropped and leaves `rd_valid` at 0 on the next clock.
- R5: An accepted read raises `rd_valid` for one cycle, starting on the clock after the request, with the word on `rd_data`. When `rd_valid` is 0, `rd_data` is all zeros.
- R6: A read and a write requested in the same cycle are each accepted or refused based on the flags before that clock edge. When full, the read goes through and the write is refused. When empty, the write goes through and the read is refused.
- R7: Exactly one slice owns the write token and exactly one owns the read token at all times. A slice's write-pass or read-pass strobe moves the matching token to the next slice on the following clock.
- R8: The token from the last slice returns to slice 0, so storage is reused around the ring indefinitely without loss or reordering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request for this cycle |
| rd_data | output | WIDTH | Word read, zero when not valid |
| rd_valid | output | 1 | rd_data holds a word read on the previous clock |
| full | output | 1 | Every slice is full |
| empty | output | 1 | Every slice is empty |

## Verification
The assertions assume that `rst_n` is released away from a clock edge, and that `wr_en` and `rd_en` are low while reset is asserted. Under those assumptions, the first look into the past after reset sees no request. The checks also rely on the slice straps being fixed, with exactly one slice strapped as first load. The bench holds both requests low through reset and changes every input only on the falling clock edge. It drives the flags to both extremes on purpose, including requests against a full queue, requests against an empty queue, and simultaneous requests at each limit. This keeps refused accesses inside what the properties expect.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

  // Handoff strobes travelling from one slice to its successor.
  typedef struct packed {
    logic wr_pass;
    logic rd_pass;
  } xpass_t;

  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/ring_slice_mem.sv
module ring_slice_mem #(
  parameter  int DEPTH = 4,
  parameter  int WIDTH = 9,
  localparam int PW    = ring_fifo_pkg::ptr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] q_q, q_d;
  logic             v_q, v_d;

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_comb begin
    v_d = re;
    q_d = q_q;
    if (re) begin
      q_d = mem_q[raddr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
      v_q <= 1'b0;
    end else begin
      q_q <= q_d;
      v_q <= v_d;
    end
  end

  assign rvalid = v_q;
  assign rdata  = v_q ? q_q : '0;

endmodule

// File: rtl/ring_slice_ctrl.sv
module ring_slice_ctrl
  import ring_fifo_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  bit SOLO  = 1'b0,
  localparam int PW    = ptr_bits(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_load_n,
  input  xpass_t        xin,
  input  logic          wr_req,
  input  logic          rd_req,
  output xpass_t        xout,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [PW-1:0] wr_addr,
  output logic [PW-1:0] rd_addr,
  output logic          slice_full,
  output logic          slice_empty,
  output logic          wr_tok,
  output logic          rd_tok
);

  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          w_last, r_last;

  assign slice_full  = (cnt_q == CW'(DEPTH));
  assign slice_empty = (cnt_q == '0);
  assign w_last      = (wptr_q == PW'(DEPTH - 1));
  assign r_last      = (rptr_q == PW'(DEPTH - 1));
  assign wr_fire     = wr_req & wr_tok & ~slice_full;
  assign rd_fire     = rd_req & rd_tok & ~slice_empty;
  assign wr_addr     = wptr_q;
  assign rd_addr     = rptr_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (wr_fire) begin
      wptr_d = w_last ? '0 : wptr_q + PW'(1);
    end
    if (rd_fire) begin
      rptr_d = r_last ? '0 : rptr_q + PW'(1);
    end
    cnt_d = cnt_q + CW'(wr_fire) - CW'(rd_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  if (SOLO) begin : g_solo
    // Expansion input tied low: the slice owns both accesses for good.
    assign wr_tok = 1'b1;
    assign rd_tok = 1'b1;
    assign xout   = '0;
  end else begin : g_chain
    logic wt_q, wt_d, rt_q, rt_d;

    assign xout = '{wr_pass: wr_fire & w_last, rd_pass: rd_fire & r_last};

    always_comb begin
      wt_d = (wt_q & ~xout.wr_pass) | xin.wr_pass;
      rt_d = (rt_q & ~xout.rd_pass) | xin.rd_pass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wt_q <= ~first_load_n;
        rt_q <= ~first_load_n;
      end else begin
        wt_q <= wt_d;
        rt_q <= rt_d;
      end
    end

    assign wr_tok = wt_q;
    assign rd_tok = rt_q;
  end

endmodule

// File: rtl/ring_slice.sv
module ring_slice
  import ring_fifo_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int WIDTH = 9,
  parameter  bit SOLO  = 1'b0,
  localparam int PW    = ptr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  xpass_t           xin,
  output xpass_t           xout,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             slice_full,
  output logic             slice_empty,
  output logic             wr_tok,
  output logic             rd_tok
);

  logic          wr_fire, rd_fire;
  logic [PW-1:0] wr_addr, rd_addr;

  ring_slice_ctrl #(
    .DEPTH (DEPTH),
    .SOLO  (SOLO)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .first_load_n (first_load_n),
    .xin          (xin),
    .wr_req       (wr_en),
    .rd_req       (rd_en),
    .xout         (xout),
    .wr_fire      (wr_fire),
    .rd_fire      (rd_fire),
    .wr_addr      (wr_addr),
    .rd_addr      (rd_addr),
    .slice_full   (slice_full),
    .slice_empty  (slice_empty),
    .wr_tok       (wr_tok),
    .rd_tok       (rd_tok)
  );

  ring_slice_mem #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_fire),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .re     (rd_fire),
    .raddr  (rd_addr),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );

endmodule

// File: rtl/ring_fifo.sv
module ring_fifo
  import ring_fifo_pkg::*;
#(
  parameter int N_SLICES    = 4,
  parameter int SLICE_DEPTH = 4,
  parameter int WIDTH       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full,
  output logic             empty
);

  localparam bit SOLO = (N_SLICES == 1);

  xpass_t              xo_v [N_SLICES];
  logic [N_SLICES-1:0] wtok_v, rtok_v, wpass_v, rpass_v;
  logic [N_SLICES-1:0] full_v, empty_v, val_v;
  logic [WIDTH-1:0]    dat_v [N_SLICES];

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    localparam int PREV = (i + N_SLICES - 1) % N_SLICES;
    xpass_t xin_i;

    if (SOLO) begin : g_tie
      assign xin_i = '0;
    end else begin : g_link
      assign xin_i = xo_v[PREV];
    end

    ring_slice #(
      .DEPTH (SLICE_DEPTH),
      .WIDTH (WIDTH),
      .SOLO  (SOLO)
    ) u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .first_load_n ((i == 0) ? 1'b0 : 1'b1),
      .xin          (xin_i),
      .xout         (xo_v[i]),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_en        (rd_en),
      .rd_data      (dat_v[i]),
      .rd_valid     (val_v[i]),
      .slice_full   (full_v[i]),
      .slice_empty  (empty_v[i]),
      .wr_tok       (wtok_v[i]),
      .rd_tok       (rtok_v[i])
    );

    assign wpass_v[i] = xo_v[i].wr_pass;
    assign rpass_v[i] = xo_v[i].rd_pass;
  end

  // Non-owning slices hold zero on their data, so an OR merges them.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_SLICES; i++) begin
      rd_data = rd_data | dat_v[i];
    end
  end

  assign rd_valid = |val_v;
  assign full     = &full_v;
  assign empty    = &empty_v;

endmodule

// File: rtl/ring_fifo_chk.sv
module ring_fifo_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic         full,
  input logic         empty,
  input logic         rd_valid,
  input logic [N-1:0] wtok_v,
  input logic [N-1:0] rtok_v,
  input logic [N-1:0] wpass_v,
  input logic [N-1:0] rpass_v
);

  assert_one_write_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok_v) == 1);

  assert_one_read_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok_v) == 1);

  assert_single_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wpass_v) && $onehot0(rpass_v));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en |=> full);

  assert_flags_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en |=> !rd_valid);

  assert_empty_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !wr_en |=> empty);

  assert_valid_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en) && !$past(empty));

  for (genvar i = 0; i < N; i++) begin : g_pass
    localparam int NXT = (i + 1) % N;

    assert_wpass_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wpass_v[i] |=> wtok_v[NXT]);

    assert_rpass_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rpass_v[i] |=> rtok_v[NXT]);
  end

endmodule

bind ring_fifo ring_fifo_chk #(.N(N_SLICES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .full     (full),
  .empty    (empty),
  .rd_valid (rd_valid),
  .wtok_v   (wtok_v),
  .rtok_v   (rtok_v),
  .wpass_v  (wpass_v),
  .rpass_v  (rpass_v)
);

// File: tb/ring_fifo_tb.sv
module ring_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS  = 4;
  localparam int SD  = 4;
  localparam int W   = 9;
  localparam int CAP = NS * SD;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, rd_en;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic         rd_valid, full, empty;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ring_fifo #(.N_SLICES(NS), .SLICE_DEPTH(SD), .WIDTH(W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .full     (full),
    .empty    (empty)
  );

  int    model_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    nd    = 1;
  bit    done  = 1'b0;
  string tag   = "R2";

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input bit re, input int d);
    bit aw, ar;
    int popped;
    wr_en   = we;
    rd_en   = re;
    wr_data = d[W-1:0];
    @(posedge clk);
    aw     = we && (model_q.size() < CAP);
    ar     = re && (model_q.size() > 0);
    popped = 0;
    if (ar) popped = model_q.pop_front();
    if (aw) model_q.push_back(d & 'h1FF);
    @(negedge clk);
    check("R5 valid", int'(rd_valid), int'(ar));
    check(tag, int'(rd_data), popped);
    check("R3 full", int'(full), int'(model_q.size() == CAP));
    check("R4 empty", int'(empty), int'(model_q.size() == 0));
  endtask

  task automatic put(input int cnt);
    for (int k = 0; k < cnt; k++) begin
      step(1'b1, 1'b0, nd);
      nd = (nd + 1) & 'hFF;
    end
  endtask

  task automatic take(input int cnt);
    for (int k = 0; k < cnt; k++) step(1'b0, 1'b1, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    rd_en   = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 empty in reset", int'(empty), 1);
    check("R1 full in reset", int'(full), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 valid", int'(rd_valid), 0);
    check("R1 data", int'(rd_data), 0);

    tag = "R4 read while empty";
    take(3);

    tag = "R7 fill across slices";
    put(CAP);
    tag = "R3 write while full";
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 'h1AA);

    tag = "R2 drain order";
    take(CAP);
    tag = "R4 read past empty";
    take(2);

    tag = "R8 ring reuse";
    put(10);
    take(6);
    put(10);
    take(15);

    tag = "R6 both at full";
    put(CAP);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b1, nd);
      nd = (nd + 1) & 'hFF;
    end
    tag = "R6 both at empty";
    take(CAP);
    step(1'b1, 1'b1, nd);
    nd = (nd + 1) & 'hFF;

    tag = "R6 mixed traffic";
    for (int k = 0; k < 300; k++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), nd);
      nd = (nd + 1) & 'hFF;
    end
    tag = "R2 final drain";
    take(CAP + 2);

    wr_en = 1'b0;
    rd_en = 1'b0;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      finish_run();
    end
  end

endmodule